// File: doc/BRIEF.md
# Spatial Region Compactor with Recency List

This block watches the stream of retired instruction addresses and compresses it into spatial regions. A region is named by its trigger address and carries two footprint vectors. One vector marks the cache blocks touched after the trigger block. The other marks the blocks touched before it. The block holds one active region. It also holds a short list of regions that were active recently, kept in recency order.

When control flow leaves the active region, the block first searches that list. This lets code that bounces between a few regions, such as a loop calling a helper, fold back into the regions already open. In that case no fresh entry is started. Only when no listed region covers the address is the outgoing region handed to a downstream history store as a one-cycle record.

The block accepts one address per cycle. It never stalls, and the record port carries no back-pressure.

Top module: `region_compactor`

## Requirements
- R1: The first retired address after reset becomes the active trigger, with both vectors cleared, and produces no record.
- R2: A retired address in the same block as the active trigger (block = address >> BLK_LOG) is a region hit. It leaves both vectors unchanged and produces no record.
- R3: A retired address d blocks after the trigger block, with 1 <= d <= SUCC_N, sets bit d-1 of the active successor vector and produces no record.
- R4: A retired address d blocks before the trigger block, with 1 <= d <= PREC_N, sets bit d-1 of the active predecessor vector and produces no record.
- R5: An address outside the active region that lies inside the region of a listed entry behaves as follows:
  - that entry leaves the list and becomes active, with its vectors unchanged (the search sets no bits);
  - the previously active region is appended as the most recent list entry;
  - no record is produced.
- R6: When several listed entries cover the address, the oldest one is reactivated.
- R7: An address that no region covers behaves as follows:
  - the cycle after it is presented, rec_valid is high and the record fields hold the outgoing region's trigger, predecessor vector and successor vector;
  - the outgoing region is appended as the most recent list entry;
  - the address becomes the new trigger, with both vectors cleared.
- R8: When the list already holds DEPTH entries and a miss occurs, the least recent entry is dropped before the append. A later address that only the dropped entry covered is therefore a miss.
- R9: rec_valid is high for exactly one cycle per miss. Misses on consecutive cycles give records on consecutive cycles, and no other event raises rec_valid.
- R10: Reset clears the active region and empties the list, and rec_valid is low while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_valid | input | 1 | A retired address is presented this cycle |
| ret_addr | input | ADDR_W | Retired instruction address |
| rec_valid | output | 1 | One-cycle pulse: the record fields hold an abandoned region |
| rec_trigger | output | ADDR_W | Trigger address of the abandoned region |
| rec_prec | output | PREC_N | Predecessor footprint; bit i means trigger block minus (i+1) |
| rec_succ | output | SUCC_N | Successor footprint; bit i means trigger block plus (i+1) |

## Verification
On a miss against a full list, three things happen in the same cycle:
- the record is emitted;
- the least recent entry is dropped;
- the outgoing region is appended at the most recent position.

The bench provokes this by walking through more distinct regions than the list can hold. It then returns both to a region that was just dropped and to one that survived. The records seen afterwards show which entries remained. They also show the footprint each entry had gathered, compared against an independent model of the list.

A reactivation can also fall on an address that two overlapping listed regions both cover. That case is judged by the trigger of the record emitted when the reactivated region is later abandoned.

// File: rtl/region_compactor.sv
module region_compactor #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LOG = 2,
  parameter int PREC_N  = 4,
  parameter int SUCC_N  = 8,
  parameter int DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_trigger,
  output logic [PREC_N-1:0] rec_prec,
  output logic [SUCC_N-1:0] rec_succ
);
  localparam int BW = ADDR_W - BLK_LOG;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] trig;
    logic [PREC_N-1:0] prec;
    logic [SUCC_N-1:0] succ;
  } ent_t;

  function automatic logic in_region(input logic [ADDR_W-1:0] trig,
                                     input logic [ADDR_W-1:0] a);
    logic [BW-1:0] tb;
    logic [BW-1:0] ab;
    tb = trig[ADDR_W-1:BLK_LOG];
    ab = a[ADDR_W-1:BLK_LOG];
    if (ab >= tb) return (ab - tb) <= BW'(SUCC_N);
    return (tb - ab) <= BW'(PREC_N);
  endfunction

  ent_t             cur_q, cur_d;
  logic             cur_vld_q, cur_vld_d;
  ent_t             lst_q [DEPTH];
  ent_t             lst_d [DEPTH];
  logic [DEPTH-1:0] lvld_q, lvld_d;
  logic [DEPTH-1:0] lmatch;
  logic             rec_d;
  ent_t             rec_q, rec_ent_d;

  logic [BW-1:0] a_blk, t_blk, d_up, d_dn;
  assign a_blk = ret_addr[ADDR_W-1:BLK_LOG];
  assign t_blk = cur_q.trig[ADDR_W-1:BLK_LOG];
  assign d_up  = a_blk - t_blk;
  assign d_dn  = t_blk - a_blk;

  logic cur_hit;
  assign cur_hit = cur_vld_q && in_region(cur_q.trig, ret_addr);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lmatch[g] = lvld_q[g] && in_region(lst_q[g].trig, ret_addr);
  end

  logic [CW-1:0] sel, cnt, rk, pos;
  logic          any_m, do_rm;

  always_comb begin
    sel   = '0;
    any_m = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lmatch[i]) begin
        any_m = 1'b1;
        sel   = CW'(i);
      end
    end
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(lvld_q[i]);
    do_rm = any_m || (cnt == CW'(DEPTH));
    rk    = any_m ? sel : '0;
    pos   = cnt - CW'(do_rm);
  end

  always_comb begin
    cur_d     = cur_q;
    cur_vld_d = cur_vld_q;
    lst_d     = lst_q;
    lvld_d    = lvld_q;
    rec_d     = 1'b0;
    rec_ent_d = rec_q;
    if (ret_valid) begin
      if (!cur_vld_q) begin
        cur_d     = '{trig: ret_addr, prec: '0, succ: '0};
        cur_vld_d = 1'b1;
      end else if (cur_hit) begin
        for (int i = 0; i < SUCC_N; i++)
          if (a_blk > t_blk && d_up == BW'(i + 1)) cur_d.succ[i] = 1'b1;
        for (int i = 0; i < PREC_N; i++)
          if (a_blk < t_blk && d_dn == BW'(i + 1)) cur_d.prec[i] = 1'b1;
      end else begin
        if (do_rm) begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            if (CW'(i) >= rk) begin
              lst_d[i]  = lst_q[i+1];
              lvld_d[i] = lvld_q[i+1];
            end
          end
          lvld_d[DEPTH-1] = 1'b0;
        end
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) == pos) begin
            lst_d[i]  = cur_q;
            lvld_d[i] = 1'b1;
          end
        end
        if (any_m) begin
          for (int i = 0; i < DEPTH; i++)
            if (CW'(i) == sel) cur_d = lst_q[i];
        end else begin
          rec_d     = 1'b1;
          rec_ent_d = cur_q;
          cur_d     = '{trig: ret_addr, prec: '0, succ: '0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      cur_vld_q <= 1'b0;
      lvld_q    <= '0;
      rec_valid <= 1'b0;
      rec_q     <= '0;
      for (int i = 0; i < DEPTH; i++) lst_q[i] <= '0;
    end else begin
      cur_q     <= cur_d;
      cur_vld_q <= cur_vld_d;
      lvld_q    <= lvld_d;
      rec_valid <= rec_d;
      rec_q     <= rec_ent_d;
      lst_q     <= lst_d;
    end
  end

  assign rec_trigger = rec_q.trig;
  assign rec_prec    = rec_q.prec;
  assign rec_succ    = rec_q.succ;
endmodule

// File: rtl/region_compactor_chk.sv
module region_compactor_chk #(
  parameter int BW    = 30,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic [BW-1:0]    ret_blk,
  input logic             rec_valid,
  input logic [BW-1:0]    rec_blk,
  input logic [DEPTH-1:0] lvld
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= seen | ret_valid;
  end

  a_r9_rec_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(ret_valid));

  a_r1_first_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(seen));

  a_r7_rec_outside_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_blk != $past(ret_blk));

  a_r8_list_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (lvld & (lvld + 1'b1)) == '0);

  a_r5_list_grows_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvld) <= $past($countones(lvld)) + 1);

  a_r10_reset_empty: assert property (@(posedge clk)
    !rst_n |-> (lvld == '0 && !rec_valid));
endmodule

bind region_compactor region_compactor_chk #(
  .BW(ADDR_W - BLK_LOG), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid),
  .ret_blk(ret_addr[ADDR_W-1:BLK_LOG]), .rec_valid(rec_valid),
  .rec_blk(rec_trigger[ADDR_W-1:BLK_LOG]), .lvld(lvld_q)
);

// File: tb/region_compactor_tb.sv
`timescale 1ns/1ps
module region_compactor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_addr = '0;
  logic        rec_valid;
  logic [31:0] rec_trigger;
  logic [3:0]  rec_prec;
  logic [7:0]  rec_succ;

  always #4 clk = ~clk;

  region_compactor u_dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .rec_valid(rec_valid), .rec_trigger(rec_trigger),
    .rec_prec(rec_prec), .rec_succ(rec_succ)
  );

  typedef struct { logic [31:0] trig; logic [3:0] prec; logic [7:0] succ; } ment_t;
  typedef struct { bit rec; ment_t e; string tag; } exp_t;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  ment_t m_cur;
  bit    m_cv;
  ment_t m_lst[$];
  exp_t  exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic bit m_in(ment_t e, logic [31:0] a);
    longint tb = longint'(e.trig >> 2);
    longint ab = longint'(a >> 2);
    if (ab >= tb) return (ab - tb) <= 8;
    return (tb - ab) <= 4;
  endfunction

  task automatic retire(input logic [31:0] a, input string tag);
    exp_t   x;
    int     k;
    ment_t  tmp;
    longint tb, ab;
    @(negedge clk);
    ret_valid = 1'b1;
    ret_addr  = a;
    x.rec = 0;
    x.tag = tag;
    x.e   = '{32'h0, 4'h0, 8'h0};
    if (!m_cv) begin
      m_cur = '{a, 4'h0, 8'h0};
      m_cv  = 1;
    end else if (m_in(m_cur, a)) begin
      tb = longint'(m_cur.trig >> 2);
      ab = longint'(a >> 2);
      if (ab > tb)      m_cur.succ[int'(ab - tb - 1)] = 1'b1;
      else if (ab < tb) m_cur.prec[int'(tb - ab - 1)] = 1'b1;
    end else begin
      k = -1;
      for (int i = 0; i < m_lst.size(); i++)
        if (k < 0 && m_in(m_lst[i], a)) k = i;
      if (k >= 0) begin
        tmp = m_lst[k];
        m_lst.delete(k);
        m_lst.push_back(m_cur);
        m_cur = tmp;
      end else begin
        if (m_lst.size() == 4) void'(m_lst.pop_front());
        m_lst.push_back(m_cur);
        x.rec = 1;
        x.e   = m_cur;
        m_cur = '{a, 4'h0, 8'h0};
      end
    end
    exp_q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ret_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    idle(3);
    rst_n = 1'b0;
    m_cv  = 0;
    m_lst.delete();
    @(negedge clk);
    check(rec_valid == 1'b0, "R10", "rec_valid in reset", 32'(rec_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin : mon
    exp_t x;
    #2;
    if (rst_n && !done) begin
      if (exp_q.size() > 0) begin
        x = exp_q.pop_front();
        check(rec_valid == x.rec, x.tag, "rec_valid", 32'(rec_valid), 32'(x.rec));
        if (x.rec && rec_valid) begin
          check(rec_trigger == x.e.trig, x.tag, "rec_trigger", rec_trigger, x.e.trig);
          check(rec_prec == x.e.prec, x.tag, "rec_prec", 32'(rec_prec), 32'(x.e.prec));
          check(rec_succ == x.e.succ, x.tag, "rec_succ", 32'(rec_succ), 32'(x.e.succ));
        end
      end else begin
        check(rec_valid == 1'b0, "R9", "idle rec_valid", 32'(rec_valid), 32'h0);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_cv = 0;
    do_reset();
    retire(32'h1000, "R1");
    retire(32'h1002, "R2");
    retire(32'h1004, "R3");
    retire(32'h1020, "R3");
    retire(32'h0FF0, "R4");
    retire(32'h0FFC, "R4");
    retire(32'h1024, "R7");
    idle(2);
    retire(32'h3000, "R7");
    retire(32'h1008, "R5");
    retire(32'h1010, "R5");
    retire(32'h7000, "R5");
    retire(32'h8000, "R9");
    retire(32'h9000, "R8");
    retire(32'h1024, "R8");
    retire(32'h3004, "R8");
    retire(32'h7008, "R8");
    idle(2);
    do_reset();
    retire(32'h7008, "R10");
    retire(32'h5000, "R10");
    retire(32'h9000, "R6");
    retire(32'h5030, "R6");
    retire(32'hA000, "R6");
    retire(32'h5020, "R6");
    retire(32'hB000, "R6");
    idle(4);
    check(exp_q.size() == 0, "R9", "pending records", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule